// File: doc/BRIEF.md
# SPI serial memory slave with page-buffered writes

This block is an SPI slave that behaves like a small byte-wide serial memory. The memory array sits inside the block as registers. The block runs on a fast system clock. It passes chip select, serial clock, serial input and the pause input through two-flop synchronisers, and it finds the serial-clock and chip-select edges from the synchronised values. Serial input is sampled on rising serial-clock edges and the output is updated on falling edges (mode 0). The output comes with a separate drive enable, so the pad can be tri-stated.

After the opcode, a read or a write takes a 16-bit address. A read then streams bytes for as long as chip select stays low. A write loads bytes into a page buffer, and the page is copied into the array during a self-timed busy window. A separate protection unit owns the write-enable latch and the protection bits. The block reports enable, disable and status-write requests to that unit as one-cycle pulses. It receives back three permits: one for write enable, one for the array page under `writeAddr`, and one for the status register. It also receives the status byte to return on a status read.

Top module: `spiee_seq`

## Requirements
- R1: After reset `soEn` and `so` are 0 and no request pulse is active. A status read then returns `{statusIn[7:1],0}`.
- R2: Opcode bytes are decoded with bit 3 ignored and bits 7..4 required to be 0. Low bits 110 pulse `setWen` and low bits 100 pulse `clrWen`, each for one cycle. For example, 0x06 and 0x0E both pulse `setWen`.
- R3: Opcode low bits 011 start a read. The next 16 bits are the address, MSB first, and only the low ADDR_BITS bits are used. Data bytes then appear MSB first, each bit driven after a falling serial clock. The address increments after each byte and wraps from the top address to 0.
- R4: Opcode low bits 010 start a write. Each data byte goes to the page offset given by the low log2(PAGE_BYTES) address bits, and that offset then increments modulo the page size while the upper bits stay fixed. Only the bytes received are changed in the array.
- R5: A write is committed only when chip select rises with at least one whole data byte received and no partial byte pending. Any other rise abandons the write.
- R6: A write is discarded at chip-select rise when `wenPermit` or `arrayPermit` is low, and no busy window starts.
- R7: A committed write or status write starts a busy window of BUSY_CYCLES clocks, after which `writeDone` pulses once. During that window a status read returns 0xFF and every other opcode is ignored: no output is driven and no request pulse is issued.
- R8: An opcode with bits 7..4 not 0, or with low bits 000 or 111, makes the block ignore serial input and leave `soEn` low until the next chip-select fall.
- R9: When the pause input is low while the serial clock is low, `soEn` drops and serial-clock edges are ignored. Raising the pause input while the serial clock is low resumes the transfer at the same bit.
- R10: Opcode low bits 001 take one data byte. On an aligned chip-select rise with `wenPermit` and `statusPermit` high, the block pulses `statusWr` with `statusWrData` equal to that byte. If either permit is low, no pulse is issued.
- R11: Opcode low bits 101 return the status byte MSB first, repeated for as long as chip select is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Pause input, active low |
| wenPermit | input | 1 | Write-enable latch state from protection unit |
| arrayPermit | input | 1 | Page under `writeAddr` may be written |
| statusPermit | input | 1 | Status register may be written |
| statusIn | input | 8 | Status byte from protection unit |
| so | output | 1 | Serial data out (0 when not driven) |
| soEn | output | 1 | Output drive enable |
| setWen | output | 1 | Request: set write enable |
| clrWen | output | 1 | Request: clear write enable |
| statusWr | output | 1 | Request: load status byte |
| statusWrData | output | 8 | Byte for status load |
| writeAddr | output | 10 | Start address of the current write |
| writeDone | output | 1 | Busy window ended |

## Verification
The bench uses the default 1024-byte array and the default 32-byte page, so the top-address wrap, the page-offset wrap and the ignored high address bits can all be reached with short transfers. BUSY_CYCLES is set to 1000. That is long enough for a status read, a blocked array read and a blocked enable command to fit inside one busy window, and short enough that about twenty committed writes fit in the cycle budget.

// File: rtl/spiee_pkg.sv
package spiee_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDRH,
    PH_ADDRL,
    PH_WDATA,
    PH_SDATA,
    PH_READ,
    PH_STAT,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    OUT_MEM,
    OUT_STAT,
    OUT_BUSY
  } outSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capBit;
    logic    addrHiLd;
    logic    addrLoLd;
    logic    bufLd;
    logic    statLd;
    logic    outLoad;
    logic    outShift;
    logic    rdInc;
    outSrc_t outSrc;
    logic    commitStart;
    logic    commitStep;
  } dpStrobe_t;

endpackage

// File: rtl/spiee_sync.sv
module spiee_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut
);

  for (genvar g = 0; g < WIDTH; g++) begin : gPin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{RST_VAL[g]}};
      else       chain <= {chain[STAGES-2:0], pinIn[g]};
    end
    assign pinOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int BUSY_CYCLES = 5000,
  parameter int PAGE_BYTES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic       holdS,
  input  logic [7:0] byteNow,
  input  logic       wenPermit,
  input  logic       arrayPermit,
  input  logic       statusPermit,
  output dpStrobe_t  st,
  output logic       soEn,
  output logic       setWen,
  output logic       clrWen,
  output logic       statusWr,
  output logic       writeDone
);

  localparam int BUSY_EFF = (BUSY_CYCLES < PAGE_BYTES) ? PAGE_BYTES : BUSY_CYCLES;
  localparam int BCW = $clog2(BUSY_EFF + 1);
  localparam logic [BCW-1:0] BUSY_LAST = BCW'(BUSY_EFF - 1);
  localparam logic [BCW-1:0] PAGE_CNT = BCW'(PAGE_BYTES);

  phase_t         phase;
  logic [2:0]     bitCnt;
  logic [2:0]     outCnt;
  logic           outStarted;
  logic           dataSeen;
  logic           isWrite;
  logic           holdActive;
  logic           csPrev;
  logic           sckPrev;
  logic           busy;
  logic           wrArr;
  logic [BCW-1:0] busyCnt;

  logic sel, csRise, sckRise, sckFall;
  logic inPhase, outPhase, capNow, byteEnd;
  logic opValid, arrayGo, statGo;
  logic [2:0] opLow;
  logic unusedOpBit;

  assign sel      = !csS;
  assign csRise   = csS && !csPrev;
  assign sckRise  = sel && !holdActive && sckS && !sckPrev;
  assign sckFall  = sel && !holdActive && !sckS && sckPrev;
  assign inPhase  = phase inside {PH_OPC, PH_ADDRH, PH_ADDRL, PH_WDATA, PH_SDATA};
  assign outPhase = phase inside {PH_READ, PH_STAT};
  assign capNow   = sckRise && inPhase;
  assign byteEnd  = capNow && (bitCnt == 3'd7);
  assign opValid  = (byteNow[7:4] == 4'd0);
  assign opLow    = byteNow[2:0];
  assign unusedOpBit = byteNow[3];

  assign arrayGo = csRise && (phase == PH_WDATA) && (bitCnt == 3'd0) && dataSeen
                   && wenPermit && arrayPermit;
  assign statGo  = csRise && (phase == PH_SDATA) && (bitCnt == 3'd0) && dataSeen
                   && wenPermit && statusPermit;

  always_comb begin
    st             = '0;
    st.capBit      = capNow;
    st.addrHiLd    = byteEnd && (phase == PH_ADDRH);
    st.addrLoLd    = byteEnd && (phase == PH_ADDRL);
    st.bufLd       = byteEnd && (phase == PH_WDATA);
    st.statLd      = byteEnd && (phase == PH_SDATA);
    st.outLoad     = sckFall && outPhase && (outCnt == 3'd0);
    st.outShift    = sckFall && outPhase && (outCnt != 3'd0);
    st.rdInc       = sckFall && (phase == PH_READ) && (outCnt == 3'd0);
    st.outSrc      = (phase == PH_READ) ? OUT_MEM : (busy ? OUT_BUSY : OUT_STAT);
    st.commitStart = arrayGo;
    st.commitStep  = busy && wrArr && (busyCnt < PAGE_CNT);
  end

  assign soEn = sel && !holdActive && outStarted && outPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_OPC;
      bitCnt     <= '0;
      outCnt     <= '0;
      outStarted <= 1'b0;
      dataSeen   <= 1'b0;
      isWrite    <= 1'b0;
      holdActive <= 1'b0;
      csPrev     <= 1'b1;
      sckPrev    <= 1'b0;
      busy       <= 1'b0;
      wrArr      <= 1'b0;
      busyCnt    <= '0;
      setWen     <= 1'b0;
      clrWen     <= 1'b0;
      statusWr   <= 1'b0;
      writeDone  <= 1'b0;
    end else begin
      csPrev    <= csS;
      sckPrev   <= sckS;
      setWen    <= 1'b0;
      clrWen    <= 1'b0;
      statusWr  <= 1'b0;
      writeDone <= 1'b0;

      if (!sel) begin
        phase      <= PH_OPC;
        bitCnt     <= '0;
        outCnt     <= '0;
        outStarted <= 1'b0;
        dataSeen   <= 1'b0;
        holdActive <= 1'b0;
      end else begin
        if (!sckS) holdActive <= !holdS;
        if (capNow) bitCnt <= bitCnt + 3'd1;
        if (sckFall && outPhase) begin
          outCnt     <= outCnt + 3'd1;
          outStarted <= 1'b1;
        end
        if (byteEnd) begin
          case (phase)
            PH_OPC: begin
              if (!opValid) begin
                phase <= PH_SKIP;
              end else if (busy) begin
                phase <= (opLow == 3'b101) ? PH_STAT : PH_SKIP;
              end else begin
                case (opLow)
                  3'b110: begin setWen <= 1'b1; phase <= PH_SKIP; end
                  3'b100: begin clrWen <= 1'b1; phase <= PH_SKIP; end
                  3'b101: phase <= PH_STAT;
                  3'b001: phase <= PH_SDATA;
                  3'b011: begin isWrite <= 1'b0; phase <= PH_ADDRH; end
                  3'b010: begin isWrite <= 1'b1; phase <= PH_ADDRH; end
                  default: phase <= PH_SKIP;
                endcase
              end
            end
            PH_ADDRH: phase <= PH_ADDRL;
            PH_ADDRL: phase <= isWrite ? PH_WDATA : PH_READ;
            PH_WDATA, PH_SDATA: dataSeen <= 1'b1;
            default: ;
          endcase
        end
      end

      if (arrayGo || statGo) begin
        busy    <= 1'b1;
        busyCnt <= '0;
        wrArr   <= arrayGo;
      end else if (busy) begin
        if (busyCnt == BUSY_LAST) begin
          busy      <= 1'b0;
          wrArr     <= 1'b0;
          writeDone <= 1'b1;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end
      if (statGo) statusWr <= 1'b1;
    end
  end

  // R7
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !st.bufLd && !st.addrLoLd);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeDone |-> $past(busy) && !busy);

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && $past(holdActive)) |-> $stable(bitCnt) && $stable(outCnt));

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setWen, clrWen, statusWr, writeDone}));

  // R10
  stat_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |-> busy && !wrArr);

endmodule

// File: rtl/spiee_data.sv
module spiee_data
  import spiee_pkg::*;
#(
  parameter int ADDR_BITS = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 siS,
  input  dpStrobe_t            st,
  input  logic [7:0]           statusIn,
  output logic [7:0]           byteNow,
  output logic                 soBit,
  output logic [7:0]           statusWrData,
  output logic [ADDR_BITS-1:0] writeAddr
);

  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int PW = $clog2(PAGE_BYTES);

  logic [6:0]           inSh;
  logic [7:0]           addrHi;
  logic [ADDR_BITS-1:0] rdAddr;
  logic [ADDR_BITS-1:0] wrAddr;
  logic [PW-1:0]        wrPtr;
  logic [PW-1:0]        walkIdx;
  logic [PAGE_BYTES-1:0] pageMask;
  logic [7:0]           outSh;
  logic [7:0]           mem [DEPTH];
  logic [7:0]           pageBuf [PAGE_BYTES];

  logic [15:0]          fullAddr;
  logic [ADDR_BITS-1:0] loadedAddr;
  logic                 unusedBits;

  assign byteNow    = {inSh, siS};
  assign fullAddr   = {addrHi, byteNow};
  assign loadedAddr = fullAddr[ADDR_BITS-1:0];
  assign unusedBits = ^{fullAddr[15:ADDR_BITS], statusIn[0]};
  assign soBit      = outSh[7];
  assign writeAddr  = wrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSh         <= '0;
      addrHi       <= '0;
      rdAddr       <= '0;
      wrAddr       <= '0;
      wrPtr        <= '0;
      walkIdx      <= '0;
      pageMask     <= '0;
      outSh        <= '0;
      statusWrData <= '0;
    end else begin
      if (st.capBit) inSh <= {inSh[5:0], siS};
      if (st.addrHiLd) addrHi <= byteNow;
      if (st.addrLoLd) begin
        rdAddr   <= loadedAddr;
        wrAddr   <= loadedAddr;
        wrPtr    <= loadedAddr[PW-1:0];
        pageMask <= '0;
      end
      if (st.bufLd) begin
        pageMask[wrPtr] <= 1'b1;
        wrPtr           <= wrPtr + 1'b1;
      end
      if (st.statLd) statusWrData <= byteNow;
      if (st.outLoad) begin
        case (st.outSrc)
          OUT_MEM:  outSh <= mem[rdAddr];
          OUT_STAT: outSh <= {statusIn[7:1], 1'b0};
          default:  outSh <= 8'hFF;
        endcase
        if (st.rdInc) rdAddr <= rdAddr + 1'b1;
      end else if (st.outShift) begin
        outSh <= {outSh[6:0], 1'b0};
      end
      if (st.commitStart) walkIdx <= '0;
      else if (st.commitStep) walkIdx <= walkIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.bufLd) pageBuf[wrPtr] <= byteNow;
    if (st.commitStep && pageMask[walkIdx])
      mem[{wrAddr[ADDR_BITS-1:PW], walkIdx}] <= pageBuf[walkIdx];
  end

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.bufLd |=> pageMask[$past(wrPtr)]);

  // R7
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.commitStep |-> !st.bufLd && !st.outLoad);

endmodule

// File: rtl/spiee_seq.sv
module spiee_seq #(
  parameter int ADDR_BITS = 10,
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sck,
  input  logic                 si,
  input  logic                 holdN,
  input  logic                 wenPermit,
  input  logic                 arrayPermit,
  input  logic                 statusPermit,
  input  logic [7:0]           statusIn,
  output logic                 so,
  output logic                 soEn,
  output logic                 setWen,
  output logic                 clrWen,
  output logic                 statusWr,
  output logic [7:0]           statusWrData,
  output logic [ADDR_BITS-1:0] writeAddr,
  output logic                 writeDone
);

  import spiee_pkg::*;

  logic       csS, sckS, siS, holdS, soBit;
  logic [7:0] byteNow;
  dpStrobe_t  st;

  spiee_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinIn({holdN, si, sck, csN}),
    .pinOut({holdS, siS, sckS, csS})
  );

  spiee_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .sckS(sckS), .holdS(holdS),
    .byteNow(byteNow), .wenPermit(wenPermit), .arrayPermit(arrayPermit),
    .statusPermit(statusPermit), .st(st), .soEn(soEn), .setWen(setWen),
    .clrWen(clrWen), .statusWr(statusWr), .writeDone(writeDone)
  );

  spiee_data #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .siS(siS), .st(st), .statusIn(statusIn),
    .byteNow(byteNow), .soBit(soBit), .statusWrData(statusWrData),
    .writeAddr(writeAddr)
  );

  assign so = soEn & soBit;

endmodule

// File: tb/spiee_seq_bench.sv
module spiee_seq_bench;

  localparam int BUSY = 1000;
  localparam int H = 6;
  localparam logic [23:0] VEC [0:4] = '{24'h0000A5, 24'h03FF3C, 24'hFC215A,
                                        24'h0155C3, 24'h021F96};

  logic clk = 0, rstN = 0;
  logic csN = 1, sck = 0, si = 0, holdN = 1;
  logic wen = 0, arrayPermit = 1, statusPermit = 1;
  logic [7:0] statusReg = 8'h00;
  logic [7:0] statusIn;
  logic so, soEn, setWen, clrWen, statusWr, writeDone;
  logic [7:0] statusWrData;
  logic [9:0] writeAddr;

  int nChecks = 0, nErr = 0, cyc = 0;
  int setCnt = 0, clrCnt = 0, stwCnt = 0, doneCnt = 0;
  logic [7:0] wrBuf [0:39];
  logic [7:0] rdBuf [0:39];
  logic [7:0] expPage [0:31];
  logic rdOe;

  assign statusIn = {statusReg[7:2], wen, 1'b0};

  spiee_seq #(.BUSY_CYCLES(BUSY)) u_spiee_seq (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .wenPermit(wen), .arrayPermit(arrayPermit), .statusPermit(statusPermit),
    .statusIn(statusIn), .so(so), .soEn(soEn), .setWen(setWen), .clrWen(clrWen),
    .statusWr(statusWr), .statusWrData(statusWrData), .writeAddr(writeAddr),
    .writeDone(writeDone)
  );

  always #5 clk = ~clk;

  // protection unit model and pulse counters
  always @(negedge clk) begin
    if (setWen) begin setCnt <= setCnt + 1; wen <= 1'b1; end
    if (clrWen || writeDone) wen <= 1'b0;
    if (clrWen) clrCnt <= clrCnt + 1;
    if (writeDone) doneCnt <= doneCnt + 1;
    if (statusWr) begin stwCnt <= stwCnt + 1; statusReg <= statusWrData; end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      nChecks = nChecks + 1;
      nErr = nErr + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nErr = nErr + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                          output logic oe);
    oe = 1'b0;
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = tx[i];
      waitClk(H);
      rx[i] = so;
      if (soEn) oe = 1'b1;
      sck = 1;
      waitClk(H);
      sck = 0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
    xferBits(tx, 8, rx, oe);
  endtask

  task automatic csLow();
    csN = 0;
    waitClk(H);
  endtask

  task automatic csHigh();
    waitClk(H);
    csN = 1;
    waitClk(2 * H);
  endtask

  task automatic sendOp(input logic [7:0] op);
    logic [7:0] r; logic o;
    csLow(); xfer(op, r, o); csHigh();
  endtask

  task automatic doWrite(input logic en, input logic [15:0] a, input int n);
    logic [7:0] r; logic o;
    if (en) sendOp(8'h06);
    csLow();
    xfer(8'h02, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
    for (int i = 0; i < n; i++) xfer(wrBuf[i], r, o);
    csHigh();
  endtask

  task automatic readArr(input logic [15:0] a, input int n);
    logic [7:0] r; logic o;
    rdOe = 1'b0;
    csLow();
    xfer(8'h03, r, o); xfer(a[15:8], r, o); xfer(a[7:0], r, o);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r, o);
      rdBuf[i] = r;
      if (o) rdOe = 1'b1;
    end
    csHigh();
  endtask

  task automatic readStat(input int n);
    logic [7:0] r; logic o;
    csLow();
    xfer(8'h05, r, o);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r, o);
      rdBuf[i] = r;
    end
    csHigh();
  endtask

  initial begin
    logic [7:0] r; logic o;
    int d0, s0;
    waitClk(3);
    rstN = 1;
    waitClk(3);

    // R1 reset state
    chk("R1 soEn after reset", soEn, 0);
    chk("R1 so after reset", so, 0);
    chk("R1 no pulses", setCnt + clrCnt + stwCnt + doneCnt, 0);
    readStat(1);
    chk("R1 status after reset", rdBuf[0], 8'h00);

    // R2 opcode decode, bit 3 ignored
    sendOp(8'h0E);
    chk("R2 0x0E pulses setWen", setCnt, 1);
    readStat(2);
    chk("R11 status shows enable", rdBuf[0], 8'h02);
    chk("R11 status repeats", rdBuf[1], 8'h02);
    sendOp(8'h0C);
    chk("R2 0x0C pulses clrWen", clrCnt, 1);
    readStat(1);
    chk("R11 status after clear", rdBuf[0], 8'h00);

    // vector table: write one byte, read back with different ignored bits
    for (int v = 0; v < 5; v++) begin
      wrBuf[0] = VEC[v][7:0];
      d0 = doneCnt;
      doWrite(1'b1, VEC[v][23:8], 1);
      waitClk(BUSY + 20);
      chk("R7 writeDone per write", doneCnt, d0 + 1);
      readArr(VEC[v][23:8] ^ 16'h8400, 1);
      chk("R3 read back", rdBuf[0], VEC[v][7:0]);
    end

    // R3 wrap from top address to zero
    readArr(16'h03FF, 2);
    chk("R3 top byte", rdBuf[0], 8'h3C);
    chk("R3 wrap to 0", rdBuf[1], 8'hA5);

    // R4 full page then wrapped partial page
    for (int i = 0; i < 32; i++) begin
      wrBuf[i] = 8'(i * 3 + 1);
      expPage[i] = 8'(i * 3 + 1);
    end
    doWrite(1'b1, 16'h0040, 32);
    waitClk(BUSY + 20);
    wrBuf[0] = 8'hE0; wrBuf[1] = 8'hE1; wrBuf[2] = 8'hE2; wrBuf[3] = 8'hE3;
    expPage[30] = 8'hE0; expPage[31] = 8'hE1; expPage[0] = 8'hE2; expPage[1] = 8'hE3;
    doWrite(1'b1, 16'h005E, 4);
    chk("R4 writeAddr", writeAddr, 10'h05E);
    waitClk(BUSY + 20);
    readArr(16'h0040, 32);
    for (int i = 0; i < 32; i++) chk("R4 page content", rdBuf[i], expPage[i]);

    // R9 hold inside a read
    csLow();
    xfer(8'h03, r, o); xfer(8'h00, r, o); xfer(8'h40, r, o);
    xfer(8'h00, r, o);
    chk("R9 byte before hold", r, expPage[0]);
    rdBuf[0] = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        holdN = 0;
        waitClk(H);
        chk("R9 soEn low in hold", soEn, 0);
        for (int k = 0; k < 3; k++) begin
          sck = 1; waitClk(H); sck = 0; waitClk(H);
        end
        chk("R9 soEn low after clocks", soEn, 0);
        holdN = 1;
        waitClk(H);
      end
      waitClk(H);
      rdBuf[0][i] = so;
      sck = 1;
      waitClk(H);
      sck = 0;
    end
    csHigh();
    chk("R9 byte across hold", rdBuf[0], expPage[1]);

    // R5 partial byte abandons write
    d0 = doneCnt;
    sendOp(8'h06);
    csLow();
    xfer(8'h02, r, o); xfer(8'h01, r, o); xfer(8'h55, r, o); xfer(8'h11, r, o);
    xferBits(8'h20, 4, r, o);
    csHigh();
    waitClk(BUSY + 20);
    chk("R5 no commit on partial", doneCnt, d0);
    readArr(16'h0155, 1);
    chk("R5 data unchanged", rdBuf[0], 8'hC3);
    sendOp(8'h04);

    // R6 no enable, then no array permit
    wrBuf[0] = 8'h00;
    doWrite(1'b0, 16'h0155, 1);
    waitClk(BUSY + 20);
    chk("R6 no commit without enable", doneCnt, d0);
    arrayPermit = 0;
    doWrite(1'b1, 16'h0155, 1);
    waitClk(BUSY + 20);
    arrayPermit = 1;
    chk("R6 no commit without permit", doneCnt, d0);
    readArr(16'h0155, 1);
    chk("R6 data unchanged", rdBuf[0], 8'hC3);
    sendOp(8'h04);

    // R7 busy window
    wrBuf[0] = 8'h77;
    s0 = setCnt;
    doWrite(1'b1, 16'h0000, 1);
    s0 = setCnt;
    readStat(1);
    chk("R7 status while busy", rdBuf[0], 8'hFF);
    readArr(16'h0155, 2);
    chk("R7 read ignored while busy", rdOe, 0);
    sendOp(8'h06);
    chk("R7 enable ignored while busy", setCnt, s0);
    waitClk(BUSY + 20);
    readStat(1);
    chk("R7 status after busy", rdBuf[0], 8'h00);
    readArr(16'h0000, 1);
    chk("R7 committed data", rdBuf[0], 8'h77);

    // R8 invalid opcodes
    s0 = setCnt;
    csLow();
    xfer(8'h07, r, o);
    xfer(8'h03, r, o); xfer(8'h01, r, o); xfer(8'h55, r, o);
    xfer(8'h00, r, o); rdOe = o;
    xfer(8'h06, r, o); if (o) rdOe = 1'b1;
    csHigh();
    chk("R8 no output after invalid", rdOe, 0);
    chk("R8 input ignored after invalid", setCnt, s0);
    sendOp(8'h86);
    chk("R8 high nibble invalid", setCnt, s0);
    readArr(16'h0155, 1);
    chk("R8 recovery on next select", rdBuf[0], 8'hC3);

    // R10 status write
    s0 = stwCnt;
    d0 = doneCnt;
    sendOp(8'h06);
    csLow(); xfer(8'h01, r, o); xfer(8'h8C, r, o); csHigh();
    chk("R10 statusWr pulse", stwCnt, s0 + 1);
    chk("R10 statusWrData", statusWrData, 8'h8C);
    waitClk(BUSY + 20);
    chk("R10 writeDone after status", doneCnt, d0 + 1);
    readStat(2);
    chk("R11 new status", rdBuf[0], 8'h8C);
    chk("R11 new status repeats", rdBuf[1], 8'h8C);
    statusPermit = 0;
    sendOp(8'h06);
    csLow(); xfer(8'h01, r, o); xfer(8'h40, r, o); csHigh();
    chk("R10 blocked without permit", stwCnt, s0 + 1);
    statusPermit = 1;
    sendOp(8'h04);

    summary();
    $finish;
  end

endmodule